// File: doc/BRIEF.md
# Prefix Flag Accumulator

This block sits beside the instruction decoder of a small processor core whose instruction set uses one-byte prefix opcodes. Each prefix byte modifies the instruction that follows it. A prefix can request indirection, a 16-bit operand size, the alternate stack, or an exchange of the accumulator with the X or Y register. The block watches every fetched opcode. It ORs the modifier bits of each prefix into a held vector and presents that vector to the decoder of the base instruction that follows. The vector is cleared once that base instruction signals completion.

A prefix and its base instruction must run as one unit. From the cycle the first prefix byte is presented until the base instruction completes, the block raises an inhibit that blocks recognition of both maskable and non-maskable interrupts. The sequencer can also force the stack-override bit low for instructions that must always use the default stack. The block also resolves which function the threaded-code opcodes (low nibble 0xB, high nibble 0 to 7) select under the current flags.

Top module: `pfx_flag_unit`

## Requirements
- R1: While reset is held, and in the first cycle after it, `pfx_flags` is 0, `int_inhibit` is 0 and `base_fn` is 0 (none).
- R2: A valid prefix byte sets one flag, visible from the cycle after the clock edge that accepts it. The bit positions are: indirect bit 0, size bit 1, stack override bit 2, A/X exchange bit 3, A/Y exchange bit 4. The opcode-to-bit mapping is 0x9B to bit 0, 0xAB to bit 1, 0x8B to bit 2, 0xEB to bit 3 and 0xFB to bit 4.
- R3: Some prefix bytes set several flags at once: 0xBB sets indirect and size (0x03), 0xCB sets stack and size (0x06), and 0xDB sets stack, indirect and size (0x07).
- R4: Consecutive prefix bytes accumulate by bitwise OR. No flag already set is cleared by a later prefix.
- R5: The flags hold through the base (non-prefix) opcode. They read 0 from the cycle after an `instr_done` that follows that base opcode.
- R6: An `instr_done` pulse that arrives while prefixes are pending and no base opcode has yet been accepted leaves the flags and the inhibit unchanged.
- R7: `int_inhibit` is 1 in the cycle a valid prefix byte is presented. It stays 1 until the cycle after the completing `instr_done`. It is 0 around a base instruction that has no prefix.
- R8: While `stk_kill` is 1, bit 2 of `pfx_flags` reads 0 and the stored stack flag is kept. When `stk_kill` returns to 0, the bit reappears.
- R9: For a valid base opcode, `base_fn` decodes as follows. Without indirect: 0x3B=5 (next), 0x4B=7 (push IP), 0x5B=9 (increment IP), 0x6B=11 (pull IP), 0x7B=13 (enter). With indirect, the same opcodes give the alternates 6, 8, 10, 12 and 14. Size alone does not select an alternate. Any other opcode, or `op_valid` low, gives 0.
- R10: Base opcode 0x0B decodes to 1 (duplicate) with neither indirect nor size, 2 (A to IP) with indirect only, 3 (IP to A) with size only, and 4 (exchange A and IP) with both.
- R11: A non-prefix opcode, and any byte presented with `op_valid` low, leaves the accumulated flags unchanged.
- R12: When `instr_done` completing a base instruction coincides with a new valid prefix byte, the next flag vector holds only that prefix's flags, and the inhibit stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_byte | input | 8 | Fetched opcode byte |
| op_valid | input | 1 | `op_byte` holds a newly fetched opcode this cycle |
| instr_done | input | 1 | The current instruction completes this cycle |
| stk_kill | input | 1 | Sequencer override forcing the stack flag output low |
| pfx_flags | output | 5 | Accumulated modifier flags for the base decoder |
| base_fn | output | 4 | Selected function for threaded-code base opcodes |
| int_inhibit | output | 1 | Blocks NMI and IRQ recognition |

## Verification
The bench builds the block with its default prefix tag nibble of 0xB. This places all eight prefix codes 0x8B to 0xFB and the threaded-code base row 0x0B to 0x7B in the same opcode column. Every single and combined prefix, chained prefixes, and every alternate function mapping are therefore reachable with real opcode values. The directed scenarios also cover the ordering corners: completion arriving before a base opcode, completion coinciding with a new prefix, and the stack-kill override applied and released around a held flag.

// File: rtl/pfx_pkg.sv
// Package: shared widths, flag positions, function codes and the
// prefix-to-flag mapping for the prefix flag accumulator.
// Assumes 8-bit opcodes with the prefix row in the upper half of one
// low-nibble column.
package pfx_pkg;

    localparam int OP_W   = 8;
    localparam int FLAG_W = 5;
    localparam int FN_W   = 4;

    localparam int F_IND = 0;
    localparam int F_WID = 1;
    localparam int F_STK = 2;
    localparam int F_AX  = 3;
    localparam int F_AY  = 4;

    typedef enum logic [FN_W-1:0] {
        FN_NONE = 4'd0,
        FN_DUP  = 4'd1,
        FN_TAI  = 4'd2,
        FN_TIA  = 4'd3,
        FN_XAI  = 4'd4,
        FN_NXT  = 4'd5,
        FN_INXT = 4'd6,
        FN_PSHI = 4'd7,
        FN_PSHW = 4'd8,
        FN_INCI = 4'd9,
        FN_INCW = 4'd10,
        FN_POPI = 4'd11,
        FN_POPW = 4'd12,
        FN_ENT  = 4'd13,
        FN_IENT = 4'd14
    } fn_t;

    // Map the low three bits of a prefix row index to its flag set.
    function automatic logic [FLAG_W-1:0] pfx_flag_set(input logic [2:0] row);
        logic [FLAG_W-1:0] m;
        m = '0;
        case (row)
            3'd0: m[F_STK] = 1'b1;
            3'd1: m[F_IND] = 1'b1;
            3'd2: m[F_WID] = 1'b1;
            3'd3: begin m[F_IND] = 1'b1; m[F_WID] = 1'b1; end
            3'd4: begin m[F_STK] = 1'b1; m[F_WID] = 1'b1; end
            3'd5: begin m[F_STK] = 1'b1; m[F_IND] = 1'b1; m[F_WID] = 1'b1; end
            3'd6: m[F_AX] = 1'b1;
            default: m[F_AY] = 1'b1;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/pfx_decode.sv
// pfx_decode: classifies an opcode byte as prefix or base.
// For prefixes it returns the set of flags the byte requests.
// Assumes prefixes occupy the upper half (bit 7 set) of the column
// whose low nibble equals TAG_NIB.
module pfx_decode
    import pfx_pkg::*;
#(
    parameter logic [3:0] TAG_NIB = 4'hB
) (
    input  logic [OP_W-1:0]   op_byte,
    output logic              pfx_hit,
    output logic              tag_col,
    output logic [FLAG_W-1:0] pfx_set
);

    // Column and row classification of the opcode byte.
    always_comb begin
        tag_col = (op_byte[3:0] == TAG_NIB);
        pfx_hit = tag_col && op_byte[OP_W-1];
        pfx_set = pfx_hit ? pfx_flag_set(op_byte[6:4]) : '0;
    end

endmodule

// File: rtl/pfx_accum.sv
// pfx_accum: holds the accumulated prefix flags, the in-sequence
// marker and the base-seen marker.
// Assumes instr_done only counts once a base opcode has been taken.
module pfx_accum
    import pfx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic              instr_done,
    input  logic              pfx_hit,
    input  logic [FLAG_W-1:0] pfx_set,
    output logic [FLAG_W-1:0] acc_q,
    output logic              in_seq_q,
    output logic              base_seen_q
);

    logic take_pfx;
    logic take_base;
    logic clr;

    // Qualify the strobes for this cycle.
    always_comb begin
        take_pfx  = op_valid && pfx_hit;
        take_base = op_valid && !pfx_hit;
        clr       = instr_done && base_seen_q;
    end

    // One sticky OR flop per flag, cleared on completion.
    for (genvar g = 0; g < FLAG_W; g++) begin : g_flag
        logic bit_q;
        always_ff @(posedge clk) begin
            if (!rst_n)
                bit_q <= 1'b0;
            else
                bit_q <= (bit_q && !clr) || (take_pfx && pfx_set[g]);
        end
        assign acc_q[g] = bit_q;
    end

    // Track whether a prefix sequence is open.
    always_ff @(posedge clk) begin
        if (!rst_n)
            in_seq_q <= 1'b0;
        else if (take_pfx)
            in_seq_q <= 1'b1;
        else if (clr)
            in_seq_q <= 1'b0;
    end

    // Track whether the base opcode of the sequence has been fetched.
    always_ff @(posedge clk) begin
        if (!rst_n)
            base_seen_q <= 1'b0;
        else if (take_base)
            base_seen_q <= 1'b1;
        else if (take_pfx || clr)
            base_seen_q <= 1'b0;
    end

endmodule

// File: rtl/pfx_fn_map.sv
// pfx_fn_map: resolves the function a threaded-code base opcode
// selects under the accumulated indirect and size flags.
// Assumes the caller qualifies with a valid non-prefix opcode in the
// tag column.
module pfx_fn_map
    import pfx_pkg::*;
(
    input  logic            sel,
    input  logic [2:0]      row,
    input  logic            ind,
    input  logic            wid,
    output logic [FN_W-1:0] fn
);

    fn_t f;

    // Row and flag combination to function code.
    always_comb begin
        f = FN_NONE;
        if (sel) begin
            case (row)
                3'd0: f = ind ? (wid ? FN_XAI : FN_TAI) : (wid ? FN_TIA : FN_DUP);
                3'd3: f = ind ? FN_INXT : FN_NXT;
                3'd4: f = ind ? FN_PSHW : FN_PSHI;
                3'd5: f = ind ? FN_INCW : FN_INCI;
                3'd6: f = ind ? FN_POPW : FN_POPI;
                3'd7: f = ind ? FN_IENT : FN_ENT;
                default: f = FN_NONE;
            endcase
        end
        fn = f;
    end

endmodule

// File: rtl/pfx_flag_unit.sv
// pfx_flag_unit: top of the prefix flag accumulator. It decodes
// prefix bytes, accumulates their flags until the base instruction
// completes, masks the stack flag on request, maps the threaded-code
// base opcodes and raises the interrupt inhibit.
// Assumes one opcode per op_valid strobe and a single-cycle instr_done.
module pfx_flag_unit
    import pfx_pkg::*;
#(
    parameter logic [3:0] TAG_NIB = 4'hB
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [OP_W-1:0]   op_byte,
    input  logic              op_valid,
    input  logic              instr_done,
    input  logic              stk_kill,
    output logic [FLAG_W-1:0] pfx_flags,
    output logic [FN_W-1:0]   base_fn,
    output logic              int_inhibit
);

    logic              pfx_hit;
    logic              tag_col;
    logic [FLAG_W-1:0] pfx_set;
    logic [FLAG_W-1:0] acc_q;
    logic              in_seq_q;
    logic              base_seen_q;
    logic [FLAG_W-1:0] kill_mask;
    logic              fn_sel;

    pfx_decode #(.TAG_NIB(TAG_NIB)) i_dec (
        .op_byte (op_byte),
        .pfx_hit (pfx_hit),
        .tag_col (tag_col),
        .pfx_set (pfx_set)
    );

    pfx_accum i_acc (
        .clk         (clk),
        .rst_n       (rst_n),
        .op_valid    (op_valid),
        .instr_done  (instr_done),
        .pfx_hit     (pfx_hit),
        .pfx_set     (pfx_set),
        .acc_q       (acc_q),
        .in_seq_q    (in_seq_q),
        .base_seen_q (base_seen_q)
    );

    // Output flags with the sequencer's stack override applied.
    always_comb begin
        kill_mask        = '1;
        kill_mask[F_STK] = !stk_kill;
        pfx_flags        = acc_q & kill_mask;
    end

    // Inhibit covers the fetch cycle of a prefix and the open sequence.
    assign int_inhibit = in_seq_q || (op_valid && pfx_hit);

    assign fn_sel = op_valid && tag_col && !pfx_hit;

    pfx_fn_map i_map (
        .sel (fn_sel),
        .row (op_byte[6:4]),
        .ind (acc_q[F_IND]),
        .wid (acc_q[F_WID]),
        .fn  (base_fn)
    );

endmodule

// File: rtl/pfx_flag_chk.sv
// pfx_flag_chk: property checker for pfx_flag_unit, bound to every
// instance. Assumes the default prefix column 0xB.
module pfx_flag_chk
    import pfx_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [OP_W-1:0]   op_byte,
    input logic              op_valid,
    input logic              instr_done,
    input logic              stk_kill,
    input logic [FLAG_W-1:0] pfx_flags,
    input logic              int_inhibit,
    input logic [FLAG_W-1:0] acc_q,
    input logic              base_seen_q
);

    logic is_pfx;
    assign is_pfx = op_valid && (op_byte[3:0] == 4'hB) && op_byte[7];

    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (acc_q == '0)); // R1

    AST_PFX_INHIBIT: assert property (@(posedge clk) disable iff (!rst_n)
        is_pfx |-> int_inhibit); // R7

    AST_OR_KEEPS_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        (is_pfx && !instr_done) |=> ((acc_q & $past(acc_q)) == $past(acc_q))); // R4

    AST_EARLY_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_done && !base_seen_q && !op_valid) |=> $stable(acc_q)); // R6

    AST_BASE_NO_TOUCH: assert property (@(posedge clk) disable iff (!rst_n)
        (!is_pfx && !instr_done) |=> $stable(acc_q)); // R11

    AST_KILL_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        stk_kill |-> !pfx_flags[F_STK]); // R8

endmodule

bind pfx_flag_unit pfx_flag_chk i_pfx_flag_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .op_byte     (op_byte),
    .op_valid    (op_valid),
    .instr_done  (instr_done),
    .stk_kill    (stk_kill),
    .pfx_flags   (pfx_flags),
    .int_inhibit (int_inhibit),
    .acc_q       (acc_q),
    .base_seen_q (base_seen_q)
);

// File: tb/test_pfx_flag_unit.sv
`timescale 1ns/1ps
// Directed bench for pfx_flag_unit: one task per scenario.
module test_pfx_flag_unit;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] op_byte = 8'h00;
    logic       op_valid = 1'b0;
    logic       instr_done = 1'b0;
    logic       stk_kill = 1'b0;
    logic [4:0] pfx_flags;
    logic [3:0] base_fn;
    logic       int_inhibit;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    pfx_flag_unit i_pfx_flag_unit (
        .clk         (clk),
        .rst_n       (rst_n),
        .op_byte     (op_byte),
        .op_valid    (op_valid),
        .instr_done  (instr_done),
        .stk_kill    (stk_kill),
        .pfx_flags   (pfx_flags),
        .base_fn     (base_fn),
        .int_inhibit (int_inhibit)
    );

    task automatic chk(input string req, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    // Apply inputs (called just after a falling edge) and settle.
    task automatic put(input logic [7:0] op, input logic v, input logic d);
        op_byte = op; op_valid = v; instr_done = d;
        #1;
    endtask

    // Advance through one rising edge to the next falling edge.
    task automatic tick();
        @(negedge clk);
    endtask

    task automatic idle();
        put(8'h00, 1'b0, 1'b0);
    endtask

    // Feed one prefix byte.
    task automatic pfx(input logic [7:0] op);
        put(op, 1'b1, 1'b0); tick(); idle();
    endtask

    // Feed a base opcode and complete it.
    task automatic base_done(input logic [7:0] op);
        put(op, 1'b1, 1'b0); tick();
        put(8'h00, 1'b0, 1'b1); tick(); idle();
    endtask

    task automatic t_reset();
        rst_n = 1'b0; idle();
        tick(); tick();
        chk("R1 flags in reset", pfx_flags, 0);
        chk("R1 inhibit in reset", int_inhibit, 0);
        rst_n = 1'b1; tick();
        chk("R1 flags after reset", pfx_flags, 0);
        chk("R1 fn after reset", base_fn, 0);
    endtask

    task automatic t_single();
        logic [7:0] ops [5] = '{8'h8B, 8'h9B, 8'hAB, 8'hEB, 8'hFB};
        int         exp [5] = '{4, 1, 2, 8, 16};
        for (int k = 0; k < 5; k++) begin
            put(ops[k], 1'b1, 1'b0);
            chk("R7 inhibit on prefix cycle", int_inhibit, 1);
            tick(); idle();
            chk("R2 single prefix", pfx_flags, exp[k]);
            base_done(8'hEA);
            chk("R5 cleared after done", pfx_flags, 0);
            chk("R7 inhibit released", int_inhibit, 0);
        end
    endtask

    task automatic t_combined();
        logic [7:0] ops [3] = '{8'hBB, 8'hCB, 8'hDB};
        int         exp [3] = '{3, 6, 7};
        for (int k = 0; k < 3; k++) begin
            pfx(ops[k]);
            chk("R3 combined prefix", pfx_flags, exp[k]);
            base_done(8'hEA);
        end
    endtask

    task automatic t_chain();
        pfx(8'h9B); chk("R4 chain step1", pfx_flags, 1);
        pfx(8'hEB); chk("R4 chain step2", pfx_flags, 9);
        pfx(8'hAB); chk("R4 chain step3", pfx_flags, 11);
        pfx(8'h9B); chk("R4 repeat keeps", pfx_flags, 11);
        base_done(8'hEA);
        chk("R5 chain cleared", pfx_flags, 0);
    endtask

    task automatic t_hold_clear();
        pfx(8'h9B);
        put(8'h7B, 1'b1, 1'b0);
        chk("R9 indirect enter", base_fn, 14);
        tick(); idle();
        chk("R5 hold after base", pfx_flags, 1);
        chk("R7 inhibit during base", int_inhibit, 1);
        tick();
        chk("R5 hold while running", pfx_flags, 1);
        put(8'h00, 1'b0, 1'b1); tick(); idle();
        chk("R5 clear on done", pfx_flags, 0);
        chk("R7 inhibit cleared", int_inhibit, 0);
    endtask

    task automatic t_early_done();
        pfx(8'hAB);
        put(8'h00, 1'b0, 1'b1); tick(); idle();
        chk("R6 early done ignored", pfx_flags, 2);
        chk("R6 inhibit held", int_inhibit, 1);
        base_done(8'hEA);
        chk("R6 later done clears", pfx_flags, 0);
    endtask

    task automatic t_kill();
        pfx(8'hCB);
        stk_kill = 1'b1; #1;
        chk("R8 stack masked", pfx_flags, 2);
        tick();
        stk_kill = 1'b0; #1;
        chk("R8 stack restored", pfx_flags, 6);
        base_done(8'hEA);
    endtask

    task automatic t_fn_alt();
        logic [7:0] ops [5] = '{8'h3B, 8'h4B, 8'h5B, 8'h6B, 8'h7B};
        for (int k = 0; k < 5; k++) begin
            put(ops[k], 1'b1, 1'b0);
            chk("R9 plain function", base_fn, 5 + 2 * k);
            chk("R7 no inhibit without prefix", int_inhibit, 0);
            tick(); put(8'h00, 1'b0, 1'b1); tick(); idle();
            pfx(8'h9B);
            put(ops[k], 1'b1, 1'b0);
            chk("R9 alternate function", base_fn, 6 + 2 * k);
            tick(); put(8'h00, 1'b0, 1'b1); tick(); idle();
        end
        pfx(8'hAB);
        put(8'h3B, 1'b1, 1'b0);
        chk("R9 size alone no alternate", base_fn, 5);
        tick(); put(8'h00, 1'b0, 1'b1); tick(); idle();
        put(8'h3B, 1'b0, 1'b0);
        chk("R9 invalid gives none", base_fn, 0);
        put(8'h80, 1'b1, 1'b0);
        chk("R9 other opcode none", base_fn, 0);
        tick(); put(8'h00, 1'b0, 1'b1); tick(); idle();
    endtask

    task automatic t_dup();
        put(8'h0B, 1'b1, 1'b0);
        chk("R10 duplicate", base_fn, 1);
        tick(); put(8'h00, 1'b0, 1'b1); tick(); idle();
        pfx(8'h9B); put(8'h0B, 1'b1, 1'b0);
        chk("R10 A to IP", base_fn, 2);
        tick(); put(8'h00, 1'b0, 1'b1); tick(); idle();
        pfx(8'hAB); put(8'h0B, 1'b1, 1'b0);
        chk("R10 IP to A", base_fn, 3);
        tick(); put(8'h00, 1'b0, 1'b1); tick(); idle();
        pfx(8'hBB); put(8'h0B, 1'b1, 1'b0);
        chk("R10 exchange combined", base_fn, 4);
        tick(); put(8'h00, 1'b0, 1'b1); tick(); idle();
        pfx(8'h9B); pfx(8'hAB); put(8'h0B, 1'b1, 1'b0);
        chk("R10 exchange chained", base_fn, 4);
        tick(); put(8'h00, 1'b0, 1'b1); tick(); idle();
    endtask

    task automatic t_base_ignored();
        pfx(8'hEB);
        put(8'h9B, 1'b0, 1'b0); tick(); idle();
        chk("R11 invalid byte ignored", pfx_flags, 8);
        put(8'h80, 1'b1, 1'b0); tick(); idle();
        chk("R11 base byte leaves flags", pfx_flags, 8);
        put(8'h00, 1'b0, 1'b1); tick(); idle();
        chk("R11 then cleared", pfx_flags, 0);
    endtask

    task automatic t_done_and_prefix();
        pfx(8'hEB);
        put(8'h80, 1'b1, 1'b0); tick();
        put(8'h9B, 1'b1, 1'b1); tick(); idle();
        chk("R12 only new prefix", pfx_flags, 1);
        chk("R12 inhibit stays", int_inhibit, 1);
        base_done(8'hEA);
        chk("R12 sequence closed", pfx_flags, 0);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_single();
        t_combined();
        t_chain();
        t_hold_clear();
        t_early_done();
        t_kill();
        t_fn_alt();
        t_dup();
        t_base_ignored();
        t_done_and_prefix();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            finished = 1'b1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule